// File: doc/BRIEF.md
# Embedded Audio Clock Recovery

This block rebuilds the audio sample-rate timing for audio carried inside a serial digital video stream. It runs entirely in one fast system clock domain. A 32-bit phase accumulator produces a tick stream at 64 times the audio sample rate, which is 3.072 MHz for 48 kHz audio. A second enable marks every 64th of those ticks, giving the sample-rate strobe.

The tick stream is held to a 24 kHz reference by a proportional-integral phase loop. In high-definition mode the reference is a pulse from an external phase decoder that reads the clock phase carried in the stream. In standard-definition mode the stream carries no phase words, so the reference is made by counting video clock enables. This ties the audio rate to the video rate. The recovered ticks are divided by 128 to form the loop's feedback, and the loop reports lock once the phase error stays small.

Top module: `audio_clk_recovery`

## Requirements
- R1: While rst_ni is low, `fs64_en_o`, `fs_en_o` and `locked_o` are low, and the increment is reset to its nominal value `NOM_INC`.
- R2: With `hd_mode_i` low, one reference tick is made for every `SD_DIV` (default 1125) cycles in which `vid_en_i` is high. Cycles with `vid_en_i` low are not counted.
- R3: `fs_en_o` is high only together with `fs64_en_o`, and exactly 64 `fs64_en_o` pulses fall between two `fs_en_o` pulses, the later one included.
- R4: `fs64_en_o` and `fs_en_o` are one system clock cycle wide. This holds while the increment stays below half the accumulator range.
- R5: With `hd_mode_i` high, the reference is `hd_ref_i`, and `vid_en_i` has no effect on the loop or on lock.
- R6: In steady state the loop makes 128 `fs64_en_o` pulses per reference period, and 2 `fs_en_o` pulses per reference period. Phase error is read at each reference tick from a 7-bit count of `fs64_en_o` pulses, taken as a signed value: positive means the feedback is ahead.
- R7: `locked_o` rises only in the cycle after a reference tick, and only on the `LOCK_CNT`-th (default 16) consecutive tick whose error magnitude is at most `TOL`. It falls in the cycle after any tick whose error magnitude exceeds `TOL`.
- R8: A change of `hd_mode_i` clears the integrator and lock in the next cycle and restores the increment to `NOM_INC`.
- R9: The 64x tick is the carry out of a 32-bit accumulator that adds the increment every cycle. With no reference ticks after a clear, the tick period is 2^32/`NOM_INC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_mode_i | input | 1 | Video standard: 1 = HD (decoder reference), 0 = SD (video-derived reference) |
| vid_en_i | input | 1 | One-cycle enable per video clock (27 MHz) in the system domain |
| hd_ref_i | input | 1 | 24 kHz reference pulse from the phase decoder |
| fs64_en_o | output | 1 | One-cycle enable at 64x sample rate |
| fs_en_o | output | 1 | One-cycle enable at sample rate |
| locked_o | output | 1 | Loop lock flag |

## Verification
In SD mode the video enable is gapped for one cycle in sixteen. The measured span of 32 sample strobes then separates counting enables (about 8738 cycles) from counting system cycles (8192). In HD mode with the reference silent and video enables still running, the span must equal the exact nominal 8192 cycles and lock must stay low, which shows that the mode change restored the increment and that the video enables are ignored. A 520-cycle decoder reference checks tracking at a second rate and counts the ticks before lock. A single reference pulse delayed by half a feedback period must drop lock, after which the loop must lock again.

// File: rtl/eacr_pkg.sv
`timescale 1ns/1ps
package eacr_pkg;
  localparam int unsigned FB_DIV = 128;
  localparam int unsigned FB_W   = $clog2(FB_DIV);
  localparam int unsigned FS_DIV = 64;
  localparam int unsigned FS_W   = $clog2(FS_DIV);
  typedef logic signed [FB_W-1:0] phase_err_t;
endpackage

// File: rtl/eacr_ref_sel.sv
`timescale 1ns/1ps
module eacr_ref_sel #(
  parameter int unsigned SD_DIV = 1125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hd_mode_i,
  input  logic vid_en_i,
  input  logic hd_ref_i,
  output logic ref_tick_o
);
  localparam int unsigned CW = $clog2(SD_DIV);

  logic [CW-1:0] sd_cnt_q;
  logic          sd_wrap;

  assign sd_wrap = !hd_mode_i && vid_en_i && (sd_cnt_q == CW'(SD_DIV-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sd_cnt_q <= '0;
    else if (clr_i)                   sd_cnt_q <= '0;
    else if (sd_wrap)                 sd_cnt_q <= '0;
    else if (!hd_mode_i && vid_en_i)  sd_cnt_q <= sd_cnt_q + 1'b1;
  end

  assign ref_tick_o = hd_mode_i ? hd_ref_i : sd_wrap;
endmodule

// File: rtl/eacr_nco.sv
`timescale 1ns/1ps
module eacr_nco
  import eacr_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic             fs64_en_o,
  output logic             fs_en_o,
  output phase_err_t       phase_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [FB_W-1:0]  fb_q;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      fb_q      <= '0;
      fs64_en_o <= 1'b0;
      fs_en_o   <= 1'b0;
    end else begin
      acc_q     <= sum[ACC_W-1:0];
      fs64_en_o <= sum[ACC_W];
      fs_en_o   <= sum[ACC_W] && (fb_q[FS_W-1:0] == '1);
      if (sum[ACC_W]) fb_q <= fb_q + 1'b1;
    end
  end

  // feedback divider read as signed: upper half means behind the reference
  assign phase_o = $signed(fb_q);
endmodule

// File: rtl/eacr_loop_filter.sv
`timescale 1ns/1ps
module eacr_loop_filter
  import eacr_pkg::*;
#(
  parameter int unsigned       ACC_W    = 32,
  parameter logic [ACC_W-1:0]  NOM_INC  = 32'd52776558,
  parameter int unsigned       KP_SH    = 17,
  parameter int unsigned       KI_SH    = 14,
  parameter int unsigned       TOL      = 2,
  parameter int unsigned       LOCK_CNT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ref_tick_i,
  input  phase_err_t       err_i,
  output logic [ACC_W-1:0] inc_o,
  output logic             locked_o
);
  localparam int unsigned LC_W = $clog2(LOCK_CNT+1);

  logic signed [ACC_W-1:0] err_x, prop, integ_q, integ_n;
  logic [ACC_W-1:0]        inc_n;
  logic [FB_W-1:0]         e_u, mag;
  logic                    in_tol;
  logic [LC_W-1:0]         good_q;

  always_comb begin
    err_x   = {{(ACC_W-FB_W){err_i[FB_W-1]}}, err_i};
    prop    = err_x <<< KP_SH;
    integ_n = integ_q + (err_x <<< KI_SH);
    inc_n   = NOM_INC - $unsigned(prop) - $unsigned(integ_n);
    e_u     = err_i;
    mag     = e_u[FB_W-1] ? (~e_u + 1'b1) : e_u;
    in_tol  = (mag <= FB_W'(TOL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q  <= '0;
      inc_o    <= NOM_INC;
      good_q   <= '0;
      locked_o <= 1'b0;
    end else if (clr_i) begin
      integ_q  <= '0;
      inc_o    <= NOM_INC;
      good_q   <= '0;
      locked_o <= 1'b0;
    end else if (ref_tick_i) begin
      integ_q <= integ_n;
      inc_o   <= inc_n;
      if (in_tol) begin
        if (good_q != LC_W'(LOCK_CNT)) good_q <= good_q + 1'b1;
        if (good_q >= LC_W'(LOCK_CNT-1)) locked_o <= 1'b1;
      end else begin
        good_q   <= '0;
        locked_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_clk_recovery.sv
`timescale 1ns/1ps
module audio_clk_recovery
  import eacr_pkg::*;
#(
  parameter int unsigned      ACC_W    = 32,
  parameter logic [ACC_W-1:0] NOM_INC  = 32'd52776558,
  parameter int unsigned      SD_DIV   = 1125,
  parameter int unsigned      KP_SH    = 17,
  parameter int unsigned      KI_SH    = 14,
  parameter int unsigned      TOL      = 2,
  parameter int unsigned      LOCK_CNT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hd_mode_i,
  input  logic vid_en_i,
  input  logic hd_ref_i,
  output logic fs64_en_o,
  output logic fs_en_o,
  output logic locked_o
);
  logic             hd_mode_q;
  logic             std_clr;
  logic             ref_tick;
  phase_err_t       phase_err;
  logic [ACC_W-1:0] inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hd_mode_q <= 1'b0;
    else         hd_mode_q <= hd_mode_i;
  end

  assign std_clr = hd_mode_i ^ hd_mode_q;

  eacr_ref_sel #(.SD_DIV(SD_DIV)) u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (std_clr),
    .hd_mode_i  (hd_mode_i),
    .vid_en_i   (vid_en_i),
    .hd_ref_i   (hd_ref_i),
    .ref_tick_o (ref_tick)
  );

  eacr_loop_filter #(
    .ACC_W(ACC_W), .NOM_INC(NOM_INC), .KP_SH(KP_SH), .KI_SH(KI_SH),
    .TOL(TOL), .LOCK_CNT(LOCK_CNT)
  ) u_lf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (std_clr),
    .ref_tick_i (ref_tick),
    .err_i      (phase_err),
    .inc_o      (inc),
    .locked_o   (locked_o)
  );

  eacr_nco #(.ACC_W(ACC_W)) u_nco (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .fs64_en_o (fs64_en_o),
    .fs_en_o   (fs_en_o),
    .phase_o   (phase_err)
  );
endmodule

// File: rtl/audio_clk_recovery_chk.sv
`timescale 1ns/1ps
module audio_clk_recovery_chk
  import eacr_pkg::*;
#(
  parameter int unsigned TOL = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hd_mode_i,
  input logic       fs64_en_o,
  input logic       fs_en_o,
  input logic       locked_o,
  input logic       ref_tick_i,
  input phase_err_t phase_err_i
);
  logic [FB_W-1:0] e_u, mag;
  assign e_u = phase_err_i;
  assign mag = e_u[FB_W-1] ? (~e_u + 1'b1) : e_u;

  p_fs_on_fs64_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_en_o |-> fs64_en_o);

  p_fs_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_en_o |=> !fs_en_o);

  p_lock_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(ref_tick_i));

  p_lock_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_tick_i && (mag > FB_W'(TOL))) |=> !locked_o);

  p_std_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hd_mode_i != $past(hd_mode_i)) |=> !locked_o);
endmodule

bind audio_clk_recovery audio_clk_recovery_chk #(.TOL(TOL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hd_mode_i   (hd_mode_i),
  .fs64_en_o   (fs64_en_o),
  .fs_en_o     (fs_en_o),
  .locked_o    (locked_o),
  .ref_tick_i  (ref_tick),
  .phase_err_i (phase_err)
);

// File: tb/audio_clk_recovery_tb_top.sv
`timescale 1ns/1ps
module audio_clk_recovery_tb_top;
  localparam logic [31:0] NOM = 32'h4000_0000;  // 4-cycle 64x period

  logic clk = 1'b0, rst_n = 1'b0, hd_mode = 1'b0, vid_en = 1'b0, hd_ref = 1'b0;
  logic fs64, fs, locked;

  always #2 clk = ~clk;

  audio_clk_recovery #(
    .ACC_W(32), .NOM_INC(NOM), .SD_DIV(512), .KP_SH(22), .KI_SH(20),
    .TOL(2), .LOCK_CNT(16)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hd_mode_i(hd_mode), .vid_en_i(vid_en),
    .hd_ref_i(hd_ref), .fs64_en_o(fs64), .fs_en_o(fs), .locked_o(locked)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) cyc++;

  // video enable gapped one cycle in sixteen
  always @(negedge clk) vid_en = ((cyc % 16) != 15);

  // decoder reference generator
  int ref_per = 520, ref_extra = 0, ref_gap = 0, ref_cnt = 0;
  bit ref_on = 0;
  always @(negedge clk) begin
    if (ref_on) begin
      if (ref_gap >= ref_per - 1 + ref_extra) begin
        hd_ref = 1'b1; ref_gap = 0; ref_extra = 0; ref_cnt++;
      end else begin
        hd_ref = 1'b0; ref_gap++;
      end
    end else begin
      hd_ref = 1'b0; ref_gap = 0;
    end
  end

  // continuous enable monitor
  int since64 = 0, bad_align = 0, bad_width = 0, bad_count = 0;
  bit prev64 = 0, prevfs = 0, seen = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      since64 = 0; seen = 0; prev64 = 0; prevfs = 0;
    end else begin
      if (fs64) since64++;
      if (fs && !fs64) bad_align++;
      if ((fs && prevfs) || (fs64 && prev64)) bad_width++;
      if (fs) begin
        if (seen && since64 != 64) bad_count++;
        seen = 1; since64 = 0;
      end
      prev64 = fs64; prevfs = fs;
    end
  end

  // scoreboard: expected spans of 32 sample strobes
  typedef struct { int exp; int tol; string req; } span_t;
  span_t sq[$];

  initial begin
    forever begin
      while (sq.size() == 0) @(negedge clk);
      begin
        int t0, cnt, span, d;
        span_t it;
        @(negedge clk);
        while (!fs) @(negedge clk);
        t0 = cyc; cnt = 0;
        while (cnt < 32) begin
          @(negedge clk);
          if (fs) cnt++;
        end
        span = cyc - t0;
        it = sq.pop_front();
        d = span - it.exp;
        if (d < 0) d = -d;
        chk(d <= it.tol, it.req, "span of 32 sample strobes", span, it.exp);
      end
    end
  end

  task automatic expect_span(int exp, int tol, string req);
    span_t it;
    it.exp = exp; it.tol = tol; it.req = req;
    sq.push_back(it);
    while (sq.size() != 0) @(negedge clk);
  endtask

  task automatic wait_lock(int max, output bit ok);
    ok = 0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (locked) begin ok = 1; break; end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
    finish_run();
  end

  initial begin
    bit ok, hi;
    int start, c;
    repeat (5) @(negedge clk);
    chk({fs64, fs, locked} == 3'b000, "R1", "outputs during reset", int'({fs64, fs, locked}), 0);
    rst_n = 1'b1;

    // SD: reference from gapped video enables, 512 enables per tick
    wait_lock(80000, ok);
    chk(ok, "R2", "SD lock reached", ok, 1);
    expect_span(8738, 12, "R2 R6");

    // switch to HD with reference silent
    hd_mode = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(locked == 1'b0, "R8", "lock cleared on standard change", locked, 0);
    expect_span(8192, 1, "R8 R9");
    hi = 0;
    repeat (6000) begin
      @(negedge clk);
      if (locked) hi = 1;
    end
    chk(!hi, "R5", "no lock from video enables in HD", hi, 0);

    // HD tracking at 520-cycle reference
    ref_per = 520; start = ref_cnt; ref_on = 1;
    wait_lock(60000, ok);
    chk(ok, "R6", "HD lock reached", ok, 1);
    chk(ref_cnt - start >= 16, "R7", "ticks before lock", ref_cnt - start, 16);
    expect_span(8320, 12, "R6");

    // phase jump of half a feedback period
    c = ref_cnt; ref_extra = 260;
    while (ref_cnt == c) @(negedge clk);
    @(negedge clk); @(negedge clk);
    chk(locked == 1'b0, "R7", "lock dropped after phase jump", locked, 0);
    wait_lock(60000, ok);
    chk(ok, "R7", "relock after phase jump", ok, 1);

    // reset while running
    rst_n = 1'b0;
    @(negedge clk);
    chk({fs64, fs, locked} == 3'b000, "R1", "outputs after mid-run reset", int'({fs64, fs, locked}), 0);
    rst_n = 1'b1;
    repeat (600) @(negedge clk);

    chk(bad_align == 0, "R3", "sample strobe without 64x tick", bad_align, 0);
    chk(bad_count == 0, "R3", "64x ticks per sample strobe not 64", bad_count, 0);
    chk(bad_width == 0, "R4", "enable wider than one cycle", bad_width, 0);
    finish_run();
  end
endmodule